// File: doc/BRIEF.md
# LIN Slave Bit-Time Resynchronizer

This block tracks the length of one LIN bit, counted in oversampling clocks, for a node acting as a LIN slave. Each clock cycle of `clk` is one sample of the receive line. While the node waits for a frame header, the bit time holds its nominal value of 32 samples. A low period on `rx` whose length falls inside the BREAK window arms a measurement of the following 0x55 SYNCH byte. The span between the first and fifth falling edges of that byte covers eight bit times, and that span yields a new bit time. The protected identifier and the response are sampled with the new value. When the surrounding controller reports the end of the response, the bit time returns to 32.

Software may switch resynchronization off through a small write port. A write with the manual flag set loads a fixed bit time, raised to at least 8 when the written value is lower. A write with the flag clear restores automatic mode and the nominal value. Writes are accepted only while the LIN controller is disabled. The bit time never adapts while the node acts as master.

Top module: `lin_bit_timer`

## Requirements
- R1: After reset `bt_cnt` is 32, `manual_on` is 0, and `sync_ok`, `sync_err` and `brk_reject` are 0.
- R2: In automatic slave mode, a low run on `rx` of 352 to 896 cycles inclusive (11 to 28 bits at 32 samples) arms the SYNCH measurement when `rx` rises. A shorter or longer run instead gives a one-cycle `brk_reject` pulse and no measurement, so `bt_cnt` stays 32.
- R3: After an accepted BREAK, let T be the number of cycles from the first to the fifth falling edge of `rx`. If T lies in 205..307, `bt_cnt` becomes floor((T+4)/8), saturated at 63, and `sync_ok` pulses for one cycle.
- R4: A T below 205 or above 307 (more than 20% from the nominal 256) gives a one-cycle `sync_err` pulse. `bt_cnt` keeps its previous value and the block waits for a new BREAK.
- R5: A measured `bt_cnt` holds through any `rx` activity until `rsp_done` is seen.
- R6: `rsp_done` after a successful measurement sets `bt_cnt` to 32 on the next cycle.
- R7: While `master_mode` is 1, no measurement takes place and `bt_cnt` does not change apart from configuration writes.
- R8: A write (`cfg_we`=1, `ctl_enable`=0) with `cfg_manual`=1 sets `manual_on` and loads `bt_cnt` with `cfg_bt`, or with 8 when `cfg_bt` is below 8. While `manual_on` is 1, headers do not change `bt_cnt`.
- R9: A write with `cfg_manual`=0 clears `manual_on` and sets `bt_cnt` to 32, whatever `cfg_bt` holds.
- R10: A write while `ctl_enable` is 1 changes neither `bt_cnt` nor `manual_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, one sample per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | LIN receive line, synchronous to clk, idle high |
| ctl_enable | input | 1 | LIN controller enabled; blocks configuration writes |
| master_mode | input | 1 | Node is a LIN master; resynchronization off |
| rsp_done | input | 1 | Pulse marking the end of the response |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_manual | input | 1 | Write data: 1 for manual bit time, 0 for automatic |
| cfg_bt | input | 6 | Write data: manual bit time |
| bt_cnt | output | 6 | Current samples per bit |
| manual_on | output | 1 | Resynchronization disabled by software |
| sync_ok | output | 1 | One-cycle pulse: new bit time taken from SYNCH |
| sync_err | output | 1 | One-cycle pulse: SYNCH outside the tolerance |
| brk_reject | output | 1 | One-cycle pulse: BREAK length outside the window |

## Verification
The assertions assume that `rx` is already synchronous to `clk`. They also assume that configuration writes happen only while the controller is disabled or are meant to be dropped, so a change of `bt_cnt` during master mode can only come from an accepted write. The stimulus changes every input on the falling clock edge. It builds each header as an exact number of low and high cycles: SYNCH bit boundaries lie at floor(k·T/8), which puts the fifth falling edge exactly T cycles after the first. Inputs change only between headers. `rsp_done` is raised only after a header has completed.

// File: rtl/lin_bt_pkg.sv
package lin_bt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC_WAIT,
        ST_MEAS,
        ST_RESP
    } bt_state_e;

endpackage

// File: rtl/lin_bt_edge.sv
module lin_bt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    output logic rx_prev,
    output logic fall,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rx_prev = prev_q;
    assign fall    = prev_q & ~rx;
    assign rise    = ~prev_q & rx;
endmodule

// File: rtl/lin_bt_quot.sv
module lin_bt_quot #(
    parameter int MEAS_W    = 9,
    parameter int BT_W      = 6,
    parameter int SYNC_BITS = 8,
    parameter int SYNC_LO   = 205,
    parameter int SYNC_HI   = 307
) (
    input  logic [MEAS_W-1:0] span,
    output logic [BT_W-1:0]   bt,
    output logic              in_range
);
    localparam logic [MEAS_W:0]   HALF_C = (MEAS_W+1)'(SYNC_BITS / 2);
    localparam logic [MEAS_W:0]   DIV_C  = (MEAS_W+1)'(SYNC_BITS);
    localparam logic [MEAS_W:0]   TOP_C  = (MEAS_W+1)'((1 << BT_W) - 1);
    localparam logic [MEAS_W-1:0] LO_C   = MEAS_W'(SYNC_LO);
    localparam logic [MEAS_W-1:0] HI_C   = MEAS_W'(SYNC_HI);

    logic [MEAS_W:0] sum, quo;

    always_comb begin
        sum      = {1'b0, span} + HALF_C;
        quo      = sum / DIV_C;
        bt       = (quo > TOP_C) ? {BT_W{1'b1}} : quo[BT_W-1:0];
        in_range = (span >= LO_C) && (span <= HI_C);
    end
endmodule

// File: rtl/lin_bit_timer.sv
module lin_bit_timer
    import lin_bt_pkg::*;
#(
    parameter int BT_W          = 6,
    parameter int DEF_BT        = 32,
    parameter int MIN_BT        = 8,
    parameter int BRK_MIN_BITS  = 11,
    parameter int BRK_MAX_BITS  = 28,
    parameter int SYNC_BITS     = 8,
    parameter int DEV_PCT       = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx,
    input  logic            ctl_enable,
    input  logic            master_mode,
    input  logic            rsp_done,
    input  logic            cfg_we,
    input  logic            cfg_manual,
    input  logic [BT_W-1:0] cfg_bt,
    output logic [BT_W-1:0] bt_cnt,
    output logic            manual_on,
    output logic            sync_ok,
    output logic            sync_err,
    output logic            brk_reject
);
    localparam int BRK_LO   = BRK_MIN_BITS * DEF_BT;
    localparam int BRK_HI   = BRK_MAX_BITS * DEF_BT;
    localparam int BRK_W    = $clog2(BRK_HI + 2);
    localparam int SYNC_NOM = SYNC_BITS * DEF_BT;
    localparam int SYNC_LO  = (SYNC_NOM * (100 - DEV_PCT) + 99) / 100;
    localparam int SYNC_HI  = (SYNC_NOM * (100 + DEV_PCT)) / 100;
    localparam int MEAS_W   = $clog2(SYNC_HI + 2);
    localparam int EDGES    = SYNC_BITS / 2 + 1;

    localparam logic [BT_W-1:0]  DEF_C    = BT_W'(DEF_BT);
    localparam logic [BT_W-1:0]  MINBT_C  = BT_W'(MIN_BT);
    localparam logic [BRK_W-1:0] BRK_LO_C = BRK_W'(BRK_LO);
    localparam logic [BRK_W-1:0] BRK_HI_C = BRK_W'(BRK_HI);
    localparam logic [BRK_W-1:0] BRK_SAT  = BRK_W'(BRK_HI + 1);
    localparam logic [MEAS_W-1:0] MEAS_HI = MEAS_W'(SYNC_HI);
    localparam logic [2:0]       LAST_E   = 3'(EDGES - 1);

    typedef struct packed {
        bt_state_e         st;
        logic [BRK_W-1:0]  brk;
        logic [MEAS_W-1:0] meas;
        logic [2:0]        edges;
        logic [BT_W-1:0]   bt;
        logic              manual;
        logic              ok;
        logic              err;
        logic              rej;
    } bt_regs_t;

    bt_regs_t r_d, r_q;

    logic rx_prev, fall, rise;
    logic [MEAS_W-1:0] span;
    logic [BT_W-1:0]   bt_new;
    logic              span_ok;

    lin_bt_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx      (rx),
        .rx_prev (rx_prev),
        .fall    (fall),
        .rise    (rise)
    );

    assign span = r_q.meas + MEAS_W'(1);

    lin_bt_quot #(
        .MEAS_W    (MEAS_W),
        .BT_W      (BT_W),
        .SYNC_BITS (SYNC_BITS),
        .SYNC_LO   (SYNC_LO),
        .SYNC_HI   (SYNC_HI)
    ) i_quot (
        .span     (span),
        .bt       (bt_new),
        .in_range (span_ok)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ok  = 1'b0;
        r_d.err = 1'b0;
        r_d.rej = 1'b0;

        if (cfg_we && !ctl_enable) begin
            r_d.manual = cfg_manual;
            if (!cfg_manual)           r_d.bt = DEF_C;
            else if (cfg_bt < MINBT_C) r_d.bt = MINBT_C;
            else                       r_d.bt = cfg_bt;
        end

        if (!ctl_enable || master_mode || r_q.manual) begin
            r_d.st    = ST_IDLE;
            r_d.brk   = '0;
            r_d.meas  = '0;
            r_d.edges = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (fall) begin
                        r_d.brk = BRK_W'(1);
                    end else if (!rx_prev && !rx) begin
                        if (r_q.brk < BRK_SAT) r_d.brk = r_q.brk + BRK_W'(1);
                    end else if (rise) begin
                        if (r_q.brk >= BRK_LO_C && r_q.brk <= BRK_HI_C)
                            r_d.st = ST_SYNC_WAIT;
                        else
                            r_d.rej = 1'b1;
                        r_d.brk = '0;
                    end
                end
                ST_SYNC_WAIT: begin
                    if (fall) begin
                        r_d.st    = ST_MEAS;
                        r_d.meas  = '0;
                        r_d.edges = 3'd1;
                    end
                end
                ST_MEAS: begin
                    if (fall && r_q.edges == LAST_E) begin
                        if (span_ok) begin
                            r_d.bt = bt_new;
                            r_d.ok = 1'b1;
                            r_d.st = ST_RESP;
                        end else begin
                            r_d.err = 1'b1;
                            r_d.st  = ST_IDLE;
                        end
                    end else if (span > MEAS_HI) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.meas = span;
                        if (fall) r_d.edges = r_q.edges + 3'd1;
                    end
                end
                ST_RESP: begin
                    if (rsp_done) begin
                        r_d.bt = DEF_C;
                        r_d.st = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.bt     <= DEF_C;
        end else begin
            r_q <= r_d;
        end
    end

    assign bt_cnt     = r_q.bt;
    assign manual_on  = r_q.manual;
    assign sync_ok    = r_q.ok;
    assign sync_err   = r_q.err;
    assign brk_reject = r_q.rej;

    // R8: the bit time never drops under the sampling minimum
    p_bt_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bt_cnt >= MINBT_C);

    // R6: end of response restores the nominal bit time
    p_rsp_revert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RESP && rsp_done && ctl_enable && !master_mode)
        |=> bt_cnt == DEF_C);

    // R7: master mode leaves the bit time alone
    p_master_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !(cfg_we && !ctl_enable)) |=> $stable(bt_cnt));

    // R4: a sync error keeps the old bit time
    p_err_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> $stable(bt_cnt));

    // R10: writes while enabled leave the mode flag untouched
    p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ctl_enable) |=> $stable(manual_on));

    // R3: completion pulse lasts one cycle
    p_ok_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |=> !sync_ok);

    // R2: reject pulse lasts one cycle and never coincides with a measurement result
    p_rej_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        brk_reject |-> !sync_ok && !sync_err);
endmodule

// File: tb/test_lin_bit_timer.sv
module test_lin_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       ctl_enable = 1'b0;
    logic       master_mode = 1'b0;
    logic       rsp_done = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_manual = 1'b0;
    logic [5:0] cfg_bt = '0;
    logic [5:0] bt_cnt;
    logic       manual_on, sync_ok, sync_err, brk_reject;

    int n_chk = 0, n_bad = 0;
    int n_ok = 0, n_err = 0, n_rej = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lin_bit_timer i_lin_bit_timer (
        .clk (clk), .rst_n (rst_n), .rx (rx), .ctl_enable (ctl_enable),
        .master_mode (master_mode), .rsp_done (rsp_done), .cfg_we (cfg_we),
        .cfg_manual (cfg_manual), .cfg_bt (cfg_bt), .bt_cnt (bt_cnt),
        .manual_on (manual_on), .sync_ok (sync_ok), .sync_err (sync_err),
        .brk_reject (brk_reject)
    );

    always @(negedge clk) begin
        if (sync_ok)    n_ok++;
        if (sync_err)   n_err++;
        if (brk_reject) n_rej++;
    end

    // break cycles, sync span T, expected bit time, kind (0 ok, 1 sync error, 2 break reject)
    localparam int NV = 10;
    localparam int VEC [NV][4] = '{
        '{416, 256, 32, 0},
        '{416, 240, 30, 0},
        '{416, 300, 38, 0},
        '{352, 205, 26, 0},
        '{896, 307, 38, 0},
        '{416, 261, 33, 0},
        '{351, 256, 32, 2},
        '{897, 256, 32, 2},
        '{416, 204, 32, 1},
        '{416, 308, 32, 1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_sync(input int t);
        for (int k = 0; k < 10; k++) begin
            logic v;
            int len;
            if (k == 0)      v = 1'b0;
            else if (k == 9) v = 1'b1;
            else             v = 1'((8'h55 >> (k - 1)) & 1);
            len = (k < 9) ? ((k + 1) * t) / 8 - (k * t) / 8 : 40;
            hold(v, len);
        end
    endtask

    task automatic send_header(input int brk, input int t);
        hold(1'b1, 20);
        hold(1'b0, brk);
        hold(1'b1, 64);
        send_sync(t);
    endtask

    task automatic cfg_write(input logic man, input logic [5:0] v);
        cfg_we = 1'b1; cfg_manual = man; cfg_bt = v;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int ok0, err0, rej0;
        repeat (3) @(negedge clk);
        chk("R1 bt", int'(bt_cnt), 32);
        chk("R1 manual", int'(manual_on), 0);
        chk("R1 pulses", int'({sync_ok, sync_err, brk_reject}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: write while enabled is dropped
        ctl_enable = 1'b1;
        cfg_write(1'b1, 6'd45);
        chk("R10 bt", int'(bt_cnt), 32);
        chk("R10 manual", int'(manual_on), 0);

        for (int i = 0; i < NV; i++) begin
            ok0 = n_ok; err0 = n_err; rej0 = n_rej;
            send_header(VEC[i][0], VEC[i][1]);
            if (VEC[i][3] == 0) begin
                chk("R3 bt", int'(bt_cnt), VEC[i][2]);
                chk("R3 ok pulse", n_ok - ok0, 1);
                chk("R2 accepted", n_rej - rej0, 0);
                // R5: response byte 0x00 does not disturb the bit time
                hold(1'b0, 9 * VEC[i][2]);
                hold(1'b1, 3 * VEC[i][2]);
                chk("R5 held", int'(bt_cnt), VEC[i][2]);
                pulse_done();
                chk("R6 revert", int'(bt_cnt), 32);
            end else if (VEC[i][3] == 1) begin
                chk("R4 bt kept", int'(bt_cnt), 32);
                chk("R4 err pulse", n_err - err0, 1);
                chk("R4 no ok", n_ok - ok0, 0);
            end else begin
                chk("R2 bt kept", int'(bt_cnt), 32);
                chk("R2 reject seen", int'(n_rej > rej0), 1);
                chk("R2 no ok", n_ok - ok0, 0);
                chk("R2 no err", n_err - err0, 0);
            end
        end

        // R8: manual load with clamp, then headers ignored
        ctl_enable = 1'b0;
        cfg_write(1'b1, 6'd5);
        chk("R8 clamp", int'(bt_cnt), 8);
        chk("R8 manual", int'(manual_on), 1);
        cfg_write(1'b1, 6'd45);
        chk("R8 load", int'(bt_cnt), 45);
        ctl_enable = 1'b1;
        ok0 = n_ok;
        send_header(416, 240);
        chk("R8 no resync", int'(bt_cnt), 45);
        chk("R8 no ok", n_ok - ok0, 0);

        // R9: automatic mode restored
        ctl_enable = 1'b0;
        cfg_write(1'b0, 6'd50);
        chk("R9 bt", int'(bt_cnt), 32);
        chk("R9 manual", int'(manual_on), 0);

        // R7: master mode blocks resync
        master_mode = 1'b1;
        ctl_enable = 1'b1;
        ok0 = n_ok;
        send_header(416, 240);
        chk("R7 bt", int'(bt_cnt), 32);
        chk("R7 no ok", n_ok - ok0, 0);

        // slave again: resync works after the other modes
        master_mode = 1'b0;
        send_header(416, 240);
        chk("R3 after master", int'(bt_cnt), 30);
        pulse_done();
        chk("R6 after master", int'(bt_cnt), 32);

        done = 1;
        summary();
        $finish;
    end
endmodule